// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC receiver's flag detector and zero-bit remover. It watches the resulting byte stream and decides, once per frame, whether the frame's address field belongs to this station. It finds frame boundaries from the flag byte 0x7E. It collects the first one or two non-flag bytes after an opening flag and compares the resulting address with four programmable address registers at the same time. Before that comparison, the received address and every register are ANDed with one shared 16-bit mask.

The mask also sets the address width. When its upper byte is zero, the filter works on 8-bit addresses and decides as soon as the first address byte arrives. Any other mask makes the filter wait for a second byte and form a 16-bit address, with the first byte received as the low half. A station address and the all-ones broadcast address can be held in two registers, so both are recognised. Unused registers should hold a copy of a used address so that they cannot match by accident.

The upstream receiver may also mark the start of a frame directly with a strobe. The decision is a one-cycle pulse that carries accept or reject and the number of the register that matched.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, and the filter ignores every byte that arrives before the first flag byte (0x7E).
- R2: The first non-flag byte after one or more flag bytes is the first address byte. Repeated flags between frames cause no decision.
- R3: In 16-bit mode the first address byte is bits 7:0 and the second is bits 15:8. Bytes 0x68 then 0xAA form 0xAA68, and bytes 0xAA then 0x68 do not.
- R4: If `cfg_mask[15:8]` is zero, the filter is in 8-bit mode and decides on the first address byte. Otherwise it is in 16-bit mode and decides on the second address byte.
- R5: Register i is taken from `cfg_addrs[16*i+15:16*i]`. It matches when (address AND `cfg_mask`) equals (register AND `cfg_mask`). All four registers are compared at once, and the frame is accepted if any register matches. Bits that the mask clears, including the whole upper byte in 8-bit mode, have no effect.
- R6: When several registers match, `dec_index` gives the lowest matching index. On a reject, `dec_index` is 0.
- R7: `dec_valid` is high for exactly one cycle, the cycle after the byte that completes the address is sampled. A frame gets exactly one decision. Bytes that follow it, up to the next flag, have no effect.
- R8: If a flag arrives before a 16-bit address is complete, the frame is dropped with no decision. That flag opens the next frame.
- R9: A valid byte that arrives with `in_sof` high is taken as the first address byte of a new frame, whatever its value, including 0x7E. Any frame in progress is abandoned without a decision.
- R10: With mask 0xFFFF, a register holding 0xFFFF accepts broadcast frames in addition to the station address held in another register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present on `in_byte` |
| in_byte | input | 8 | Received byte, flags included |
| in_sof | input | 1 | With `in_valid`, marks the byte as the first address byte of a new frame |
| cfg_mask | input | 16 | Shared address mask; its upper byte selects 8-bit or 16-bit mode |
| cfg_addrs | input | 64 | Four 16-bit address registers; register i is at bits 16i+15:16i |
| dec_valid | output | 1 | One-cycle pulse carrying the frame's decision |
| dec_accept | output | 1 | High when at least one register matched |
| dec_index | output | 2 | Lowest matching register number; 0 on a reject |

## Verification
Two of the filter's functions can fall in the same cycle.

- **Start strobe against a pending 16-bit address.** `in_sof` can arrive while a 16-bit address is still waiting for its second byte. The strobe must win: the half-collected address is dropped, and the strobed byte becomes the new low byte. The bench provokes this by sending a flag and one address byte, then a strobed byte and one more byte. It judges the result by checking that there is no decision after the strobed byte and that the final decision matches only the address built from the strobed byte.
- **Closing flag against the opening of the next frame.** One flag byte can close a short frame and open the next one. The bench checks that the short frame produces no decision and that the next frame is still recognised from the bytes that directly follow that flag.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  localparam int          BYTE_W    = 8;
  localparam int          ADDR_W    = 2 * BYTE_W;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;

  typedef enum logic [1:0] {
    FR_HUNT,   // no flag seen since reset
    FR_OPEN,   // flag seen, waiting for the first address byte
    FR_ADDR1,  // low address byte held, waiting for the high byte
    FR_BODY    // decision made, waiting for the next flag
  } fr_state_e;

  // Little-endian assembly: the first byte received is the low half.
  function automatic logic [ADDR_W-1:0] join_addr(input logic [BYTE_W-1:0] first_b,
                                                  input logic [BYTE_W-1:0] second_b,
                                                  input logic              wide);
    return wide ? {second_b, first_b} : {{BYTE_W{1'b0}}, first_b};
  endfunction

  // A non-zero upper mask byte selects 16-bit recognition.
  function automatic logic mask_is_wide(input logic [ADDR_W-1:0] m);
    return |m[ADDR_W-1:BYTE_W];
  endfunction

  // Two addresses are equal under the mask when no unmasked bit differs.
  function automatic logic masked_eq(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [ADDR_W-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

endpackage

// File: rtl/hdlc_af_framer.sv
module hdlc_af_framer
  import hdlc_af_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_sof,
  input  logic              wide,
  output logic              addr_done,
  output logic [ADDR_W-1:0] addr_word,
  output logic              short_drop
);

  fr_state_e         st_q, st_n;
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic              take_first;
  logic              is_flag;

  assign is_flag = (in_byte == FLAG_BYTE);

  always_comb begin
    st_n       = st_q;
    lo_n       = lo_q;
    addr_done  = 1'b0;
    short_drop = 1'b0;
    take_first = 1'b0;
    addr_word  = join_addr(lo_q, in_byte, 1'b1);
    if (in_valid) begin
      if (in_sof) begin
        take_first = 1'b1;
      end else if (is_flag) begin
        if (st_q == FR_ADDR1) short_drop = 1'b1;
        st_n = FR_OPEN;
      end else begin
        case (st_q)
          FR_OPEN:  take_first = 1'b1;
          FR_ADDR1: begin
            addr_done = 1'b1;
            addr_word = join_addr(lo_q, in_byte, 1'b1);
            st_n      = FR_BODY;
          end
          default: ;
        endcase
      end
      if (take_first) begin
        if (wide) begin
          lo_n = in_byte;
          st_n = FR_ADDR1;
        end else begin
          addr_done = 1'b1;
          addr_word = join_addr(in_byte, '0, 1'b0);
          st_n      = FR_BODY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= FR_HUNT;
      lo_q <= '0;
    end else begin
      st_q <= st_n;
      lo_q <= lo_n;
    end
  end

  // R8
  drop_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_drop |-> (in_valid && !in_sof && in_byte == FLAG_BYTE && !addr_done));

  // R7
  one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_BODY && !in_sof) |-> !addr_done);

  // R1
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_HUNT && !in_sof) |-> !addr_done);

endmodule

// File: rtl/hdlc_af_match.sv
module hdlc_af_match
  import hdlc_af_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_word,
  input  logic [ADDR_W-1:0]          mask,
  input  logic [NUM_REGS*ADDR_W-1:0] regs,
  output logic                       any_hit,
  output logic [IDX_W-1:0]           hit_idx
);

  logic [NUM_REGS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign hit_vec[g] = masked_eq(addr_word, regs[g*ADDR_W +: ADDR_W], mask);
  end

  assign any_hit = |hit_vec;

  // Scan from the top so the lowest matching index is the one left.
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  // R6
  idx_points_at_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[hit_idx]);

  // R6
  idx_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (hit_idx == '0));

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [7:0]                 in_byte,
  input  logic                       in_sof,
  input  logic [15:0]                cfg_mask,
  input  logic [NUM_REGS*16-1:0]     cfg_addrs,
  output logic                       dec_valid,
  output logic                       dec_accept,
  output logic [IDX_W-1:0]           dec_index
);

  logic              wide;
  logic              addr_done;
  logic [ADDR_W-1:0] addr_word;
  logic              short_drop;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;

  assign wide = mask_is_wide(cfg_mask);

  hdlc_af_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_sof     (in_sof),
    .wide       (wide),
    .addr_done  (addr_done),
    .addr_word  (addr_word),
    .short_drop (short_drop)
  );

  hdlc_af_match #(.NUM_REGS(NUM_REGS)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_word (addr_word),
    .mask      (cfg_mask),
    .regs      (cfg_addrs),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid  <= addr_done;
      dec_accept <= addr_done && any_hit;
      dec_index  <= addr_done ? hit_idx : '0;
    end
  end

  // R7
  dec_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

  // R8
  drop_gives_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_drop |=> !dec_valid);

  // R6
  reject_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |-> (dec_index == '0));

endmodule

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_sof = 1'b0;
  logic [15:0] cfg_mask = 16'hFFFF;
  logic [15:0] regs [4];
  logic [63:0] cfg_addrs;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_index;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic       obs_v, obs_a;
  logic [1:0] obs_i;
  logic [7:0] first_b;

  always #2.5 clk = ~clk;

  assign cfg_addrs = {regs[3], regs[2], regs[1], regs[0]};

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_sof(in_sof), .cfg_mask(cfg_mask), .cfg_addrs(cfg_addrs),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_index(dec_index)
  );

  // Reference decision taken from the requirements: masked compare, lowest index.
  task automatic ref_decide(input logic [15:0] addr, output logic acc, output logic [1:0] idx);
    acc = 1'b0;
    idx = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (!acc && ((addr & cfg_mask) == (regs[i] & cfg_mask))) begin
        acc = 1'b1;
        idx = 2'(i);
      end
    end
  endtask

  // Presents one byte for one cycle and captures the outputs a cycle later.
  task automatic send(input logic [7:0] b, input logic sof);
    in_valid = 1'b1;
    in_byte  = b;
    in_sof   = sof;
    @(negedge clk);
    obs_v = dec_valid;
    obs_a = dec_accept;
    obs_i = dec_index;
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    checks++;
    if (obs_v !== 1'b0) begin
      failures++;
      $display("FAIL %s: dec_valid=%b expected 0", tag, obs_v);
    end
  endtask

  task automatic expect_dec(input string tag, input logic [15:0] addr);
    logic       acc;
    logic [1:0] idx;
    ref_decide(addr, acc, idx);
    checks++;
    if (obs_v !== 1'b1 || obs_a !== acc || obs_i !== idx) begin
      failures++;
      $display("FAIL %s: valid=%b accept=%b index=%0d expected valid=1 accept=%b index=%0d",
               tag, obs_v, obs_a, obs_i, acc, idx);
    end
  endtask

  task automatic expect_fixed(input string tag, input logic acc, input logic [1:0] idx);
    checks++;
    if (obs_v !== 1'b1 || obs_a !== acc || obs_i !== idx) begin
      failures++;
      $display("FAIL %s: valid=%b accept=%b index=%0d expected valid=1 accept=%b index=%0d",
               tag, obs_v, obs_a, obs_i, acc, idx);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (dec_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: dec_valid=%b after reset expected 0", dec_valid);
    end
    cfg_mask = 16'h00FF;
    regs[0] = 16'h0055; regs[1] = 16'h0055; regs[2] = 16'h0055; regs[3] = 16'h0055;
    send(8'h55, 1'b0); expect_none("R1 byte before first flag");
    send(8'h44, 1'b0); expect_none("R1 second byte before first flag");
  endtask

  task automatic t_8bit;
    cfg_mask = 16'h00FF;
    regs[0] = 16'h1255; regs[1] = 16'h3466; regs[2] = 16'h5655; regs[3] = 16'h7877;
    send(8'h7E, 1'b0); expect_none("R2 opening flag");
    send(8'h55, 1'b0); expect_fixed("R4 R5 8-bit match, upper byte ignored", 1'b1, 2'd0);
    send(8'h44, 1'b0); expect_none("R7 body byte after decision");
    send(8'h66, 1'b0); expect_none("R7 matching-looking body byte");
    send(8'h7E, 1'b0); expect_none("R2 closing flag");
    send(8'h7E, 1'b0); expect_none("R2 repeated flag");
    send(8'h77, 1'b0); expect_fixed("R2 R5 address after repeated flags", 1'b1, 2'd3);
    send(8'h7E, 1'b0);
    send(8'h99, 1'b0); expect_fixed("R6 8-bit reject", 1'b0, 2'd0);
  endtask

  task automatic t_16bit;
    cfg_mask = 16'hFFFF;
    regs[0] = 16'hAA68; regs[1] = 16'hFFFF; regs[2] = 16'hAA68; regs[3] = 16'hAA68;
    send(8'h7E, 1'b0);
    send(8'h68, 1'b0); expect_none("R4 no decision on first byte in 16-bit mode");
    send(8'hAA, 1'b0); expect_fixed("R3 little-endian station address", 1'b1, 2'd0);
    send(8'h44, 1'b0); expect_none("R7 control byte");
    send(8'h7E, 1'b0);
    send(8'hFF, 1'b0);
    send(8'hFF, 1'b0); expect_fixed("R10 broadcast", 1'b1, 2'd1);
    send(8'h7E, 1'b0);
    send(8'h68, 1'b0);
    send(8'hAB, 1'b0); expect_dec("R5 16-bit reject", 16'hAB68);
    send(8'h7E, 1'b0);
    send(8'hAA, 1'b0);
    send(8'h68, 1'b0); expect_fixed("R3 swapped byte order rejected", 1'b0, 2'd0);
  endtask

  task automatic t_priority;
    cfg_mask = 16'h0F0F;
    regs[0] = 16'h1111; regs[1] = 16'h5204; regs[2] = 16'hA2B4; regs[3] = 16'h1234;
    send(8'h7E, 1'b0);
    send(8'h34, 1'b0);
    send(8'h12, 1'b0); expect_fixed("R6 lowest of several matches", 1'b1, 2'd1);
    regs[1] = 16'h0000;
    send(8'h7E, 1'b0);
    send(8'h34, 1'b0);
    send(8'h12, 1'b0); expect_dec("R5 masked partial compare", 16'h1234);
  endtask

  task automatic t_short;
    cfg_mask = 16'hFFFF;
    regs[0] = 16'h3412; regs[1] = 16'h3412; regs[2] = 16'h3412; regs[3] = 16'h3412;
    send(8'h7E, 1'b0);
    send(8'h68, 1'b0); expect_none("R8 half address");
    send(8'h7E, 1'b0); expect_none("R8 short frame dropped");
    send(8'h12, 1'b0); expect_none("R8 next frame first byte");
    send(8'h34, 1'b0); expect_fixed("R8 flag reopened next frame", 1'b1, 2'd0);
  endtask

  task automatic t_sof;
    cfg_mask = 16'hFFFF;
    regs[0] = 16'hAA55; regs[1] = 16'hAA68; regs[2] = 16'hAA68; regs[3] = 16'hAA68;
    send(8'h7E, 1'b0);
    first_b = 8'h68;
    send(first_b, 1'b0);
    send(8'h55, 1'b1); expect_none("R9 strobe abandons pending address");
    send(8'hAA, 1'b0); expect_fixed("R9 address built from strobed byte", 1'b1, 2'd0);
    send(8'h7E, 1'b1); expect_none("R9 strobed flag value taken as address");
    send(8'hAA, 1'b0); expect_dec("R9 flag value as low byte", 16'hAA7E);
    cfg_mask = 16'h00FF;
    regs[0] = 16'h0055; regs[1] = 16'h0055; regs[2] = 16'h0055; regs[3] = 16'h0055;
    send(8'h55, 1'b1); expect_fixed("R9 8-bit strobe without flag", 1'b1, 2'd0);
    send(8'h55, 1'b1); expect_fixed("R9 back-to-back strobed frame", 1'b1, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_8bit();
    t_16bit();
    t_priority();
    t_short();
    t_sof();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule